// File: doc/BRIEF.md
# DMA Channel Link Request Generator

This block sits beside one channel of a four-channel DMA engine. It decides when that channel should wake up another channel. Software programs five things: a 2-bit link mode, a cycle-steal enable, a primary and a secondary link-target index, and a bandwidth-control value. The channel's own index is also an input. The channel's datapath sends two event pulses. One marks the end of each cycle-steal transfer. The other marks the cycle in which the byte count reaches zero.

From these the block produces three outputs:
- a registered, one-hot request vector addressed to the four channels;
- a configuration-error flag, raised when a target index in use points back at the channel itself;
- an effective bandwidth-control value, which is cleared whenever any linking is active. This stops arbitration from interleaving other channels during a linked sequence.

Link-mode encoding:
- `2'b00`: linking off.
- `2'b01`: per-transfer link to the primary target, then a final link to the secondary target.
- `2'b10`: per-transfer link to the primary target.
- `2'b11`: a single link to the primary target when the count empties.

Top module: `dma_link_ctrl`

## Requirements
- R1: While `rst` is high, and on the first sampled cycle after it, `link_req` is all zeros, whatever the event inputs do.
- R2: With `link_mode` = 2'b00, no event ever produces a request.
- R3: With `link_mode` = 2'b01 and `steal_mode` = 1, a `xfer_done` pulse without `count_zero` requests the primary target (`link_a`).
- R4: With `link_mode` = 2'b01, a `count_zero` pulse requests only the secondary target (`link_b`). This holds even when `xfer_done` is high in the same cycle, and whatever `steal_mode` is.
- R5: With `steal_mode` = 0 in modes 2'b01 and 2'b10, `xfer_done` produces no request to the primary target.
- R6: With `link_mode` = 2'b10 and `steal_mode` = 1, `xfer_done` requests the primary target, and `count_zero` alone produces no request.
- R7: With `link_mode` = 2'b11, `count_zero` requests the primary target whatever `steal_mode` is. `xfer_done` alone produces no request.
- R8: `bwc_eff` equals `bwc_cfg` when `link_mode` = 2'b00 and is zero for any other mode. This is combinational.
- R9: `cfg_err` (combinational) is high when the mode is non-zero and either `link_a` equals `own_idx`, or the mode is 2'b01 and `link_b` equals `own_idx`. A request whose target equals `own_idx` is never issued.
- R10: A request is bit n of `link_req` for target index n. It appears on the clock edge that samples the event. It lasts one cycle unless an event is sampled again. At most one bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_mode | input | 2 | Link mode (00 off, 01 each-then-final, 10 each, 11 final) |
| steal_mode | input | 1 | Cycle-steal enable |
| link_a | input | 2 | Primary link-target index |
| link_b | input | 2 | Secondary link-target index |
| own_idx | input | 2 | Index of this channel |
| bwc_cfg | input | 3 | Programmed bandwidth-control value |
| xfer_done | input | 1 | Pulse: one cycle-steal transfer finished |
| count_zero | input | 1 | Pulse: byte count reached zero |
| link_req | output | 4 | One-hot link request to channels 0..3 |
| bwc_eff | output | 3 | Effective bandwidth-control value |
| cfg_err | output | 1 | Link configuration error |

## Verification
The bench targets the cycle in which the last transfer and the zero count arrive together in mode 01. A design that lets both fire there would send a primary request, or two bits at once, instead of the lone secondary request.

It clears the steal enable in modes 01 and 10. A design that forgets this gate would wake the primary target on every transfer.

It points a target index at the channel itself, and it checks that an unused secondary index is ignored outside mode 01. A wrong design would either request itself or flag a false configuration error.

Back-to-back events and a reset held while events are pending show whether a pulse is stretched, or leaks out of reset.

// File: rtl/dma_link_pkg.sv
package dma_link_pkg;

    typedef enum logic [1:0] {
        LM_OFF             = 2'b00,
        LM_EACH_THEN_FINAL = 2'b01,
        LM_EACH            = 2'b10,
        LM_FINAL           = 2'b11
    } link_mode_e;

    // Decision made by the event decoder for one cycle.
    typedef struct packed {
        logic fire;   // a link is due this cycle
        logic sel_b;  // target is the secondary index
    } link_pick_t;

    // True when the mode ever addresses the secondary target.
    function automatic logic mode_uses_b(input link_mode_e m);
        return (m == LM_EACH_THEN_FINAL);
    endfunction

    // True when the mode links on each cycle-steal transfer.
    function automatic logic mode_per_xfer(input link_mode_e m);
        return (m == LM_EACH_THEN_FINAL) || (m == LM_EACH);
    endfunction

endpackage

// File: rtl/link_event_decode.sv
module link_event_decode
    import dma_link_pkg::*;
(
    input  link_mode_e mode,
    input  logic       steal_mode,
    input  logic       xfer_done,
    input  logic       count_zero,
    output link_pick_t pick
);

    logic per_xfer_hit;

    // Per-transfer links exist only in cycle-steal operation.
    assign per_xfer_hit = mode_per_xfer(mode) && steal_mode && xfer_done;

    always_comb begin
        pick = '0;
        unique case (mode)
            LM_OFF: pick = '0;
            LM_EACH_THEN_FINAL: begin
                // The emptying transfer hands over to the secondary target only.
                if (count_zero) begin
                    pick.fire  = 1'b1;
                    pick.sel_b = 1'b1;
                end else if (per_xfer_hit) begin
                    pick.fire  = 1'b1;
                end
            end
            LM_EACH:  pick.fire = per_xfer_hit;
            LM_FINAL: pick.fire = count_zero;
            default:  pick = '0;
        endcase
    end

endmodule

// File: rtl/link_target_guard.sv
module link_target_guard
    import dma_link_pkg::*;
#(
    parameter int unsigned N_CH  = 4,
    parameter int unsigned IDX_W = $clog2(N_CH)
) (
    input  link_mode_e        mode,
    input  link_pick_t        pick,
    input  logic [IDX_W-1:0]  link_a,
    input  logic [IDX_W-1:0]  link_b,
    input  logic [IDX_W-1:0]  own_idx,
    output logic [N_CH-1:0]   req_next,
    output logic              cfg_err
);

    logic [IDX_W-1:0] target;
    logic             self_hit;
    logic             fire_ok;

    assign target   = pick.sel_b ? link_b : link_a;
    assign self_hit = (target == own_idx);
    assign fire_ok  = pick.fire && !self_hit;

    // A target in use that names this channel is a programming error.
    assign cfg_err = (mode != LM_OFF) &&
                     ((link_a == own_idx) || (mode_uses_b(mode) && (link_b == own_idx)));

    for (genvar c = 0; c < N_CH; c++) begin : g_dec
        assign req_next[c] = fire_ok && (target == IDX_W'(c));
    end

endmodule

// File: rtl/bwc_force.sv
module bwc_force
    import dma_link_pkg::*;
#(
    parameter int unsigned BWC_W = 3
) (
    input  link_mode_e        mode,
    input  logic [BWC_W-1:0]  bwc_cfg,
    output logic [BWC_W-1:0]  bwc_eff
);

    // Any linking pins bandwidth control at zero so no arbitration intervenes.
    assign bwc_eff = (mode == LM_OFF) ? bwc_cfg : '0;

endmodule

// File: rtl/dma_link_ctrl.sv
module dma_link_ctrl
    import dma_link_pkg::*;
#(
    parameter int unsigned N_CH  = 4,
    parameter int unsigned IDX_W = $clog2(N_CH),
    parameter int unsigned BWC_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        link_mode,
    input  logic              steal_mode,
    input  logic [IDX_W-1:0]  link_a,
    input  logic [IDX_W-1:0]  link_b,
    input  logic [IDX_W-1:0]  own_idx,
    input  logic [BWC_W-1:0]  bwc_cfg,
    input  logic              xfer_done,
    input  logic              count_zero,
    output logic [N_CH-1:0]   link_req,
    output logic [BWC_W-1:0]  bwc_eff,
    output logic              cfg_err
);

    link_mode_e       mode;
    link_pick_t       pick;
    logic [N_CH-1:0]  req_next;

    assign mode = link_mode_e'(link_mode);

    link_event_decode i_decode (
        .mode       (mode),
        .steal_mode (steal_mode),
        .xfer_done  (xfer_done),
        .count_zero (count_zero),
        .pick       (pick)
    );

    link_target_guard #(.N_CH(N_CH), .IDX_W(IDX_W)) i_guard (
        .mode     (mode),
        .pick     (pick),
        .link_a   (link_a),
        .link_b   (link_b),
        .own_idx  (own_idx),
        .req_next (req_next),
        .cfg_err  (cfg_err)
    );

    bwc_force #(.BWC_W(BWC_W)) i_bwc (
        .mode    (mode),
        .bwc_cfg (bwc_cfg),
        .bwc_eff (bwc_eff)
    );

    always_ff @(posedge clk) begin
        if (rst) link_req <= '0;
        else     link_req <= req_next;
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(link_req)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(xfer_done) && !$past(count_zero)) |-> (link_req == '0)); // R10

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(link_mode) == 2'b00) |-> (link_req == '0)); // R2

    AST_STEAL_GATE: assert property (@(posedge clk) disable iff (rst)
        ($past(link_mode) == 2'b10 && !$past(steal_mode)) |-> (link_req == '0)); // R5

    AST_NO_SELF: assert property (@(posedge clk) disable iff (rst)
        ((link_req & (N_CH'(1) << $past(own_idx))) == '0)); // R9

    AST_BWC_FORCED: assert property (@(posedge clk) disable iff (rst)
        (link_mode != 2'b00) |-> (bwc_eff == '0)); // R8

endmodule

// File: tb/test_dma_link_ctrl.sv
module test_dma_link_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] link_mode;
    logic       steal_mode;
    logic [1:0] link_a, link_b, own_idx;
    logic [2:0] bwc_cfg;
    logic       xfer_done, count_zero;
    logic [3:0] link_req;
    logic [2:0] bwc_eff;
    logic       cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    dma_link_ctrl i_dma_link_ctrl (
        .clk(clk), .rst(rst), .link_mode(link_mode), .steal_mode(steal_mode),
        .link_a(link_a), .link_b(link_b), .own_idx(own_idx), .bwc_cfg(bwc_cfg),
        .xfer_done(xfer_done), .count_zero(count_zero),
        .link_req(link_req), .bwc_eff(bwc_eff), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       steal;
        logic [1:0] a;
        logic [1:0] b;
        logic [1:0] own;
        logic [2:0] bwc;
        logic       xd;
        logic       cz;
        logic [3:0] ereq;
        logic [2:0] ebwc;
        logic       eerr;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'b00,1'b1,2'd1,2'd2,2'd0,3'd5,1'b1,1'b0,4'b0000,3'd5,1'b0,8'd2},  // R2
        '{2'b00,1'b1,2'd1,2'd2,2'd0,3'd5,1'b1,1'b1,4'b0000,3'd5,1'b0,8'd2},  // R2
        '{2'b01,1'b1,2'd1,2'd2,2'd0,3'd5,1'b1,1'b0,4'b0010,3'd0,1'b0,8'd3},  // R3
        '{2'b01,1'b1,2'd1,2'd2,2'd0,3'd5,1'b1,1'b1,4'b0100,3'd0,1'b0,8'd4},  // R4
        '{2'b01,1'b0,2'd1,2'd2,2'd0,3'd5,1'b0,1'b1,4'b0100,3'd0,1'b0,8'd4},  // R4
        '{2'b01,1'b0,2'd1,2'd2,2'd0,3'd5,1'b1,1'b0,4'b0000,3'd0,1'b0,8'd5},  // R5
        '{2'b10,1'b0,2'd1,2'd2,2'd0,3'd5,1'b1,1'b0,4'b0000,3'd0,1'b0,8'd5},  // R5
        '{2'b10,1'b1,2'd1,2'd2,2'd0,3'd5,1'b1,1'b0,4'b0010,3'd0,1'b0,8'd6},  // R6
        '{2'b10,1'b1,2'd1,2'd2,2'd0,3'd5,1'b0,1'b1,4'b0000,3'd0,1'b0,8'd6},  // R6
        '{2'b11,1'b0,2'd1,2'd2,2'd0,3'd5,1'b0,1'b1,4'b0010,3'd0,1'b0,8'd7},  // R7
        '{2'b11,1'b1,2'd1,2'd2,2'd0,3'd5,1'b1,1'b0,4'b0000,3'd0,1'b0,8'd7},  // R7
        '{2'b01,1'b1,2'd3,2'd0,2'd2,3'd5,1'b1,1'b0,4'b1000,3'd0,1'b0,8'd10}, // R10
        '{2'b01,1'b1,2'd1,2'd2,2'd1,3'd5,1'b1,1'b0,4'b0000,3'd0,1'b1,8'd9},  // R9
        '{2'b01,1'b1,2'd1,2'd2,2'd2,3'd5,1'b0,1'b1,4'b0000,3'd0,1'b1,8'd9},  // R9
        '{2'b10,1'b1,2'd1,2'd2,2'd2,3'd5,1'b1,1'b0,4'b0010,3'd0,1'b0,8'd9},  // R9
        '{2'b00,1'b1,2'd1,2'd2,2'd1,3'd7,1'b0,1'b0,4'b0000,3'd7,1'b0,8'd8},  // R8
        '{2'b11,1'b1,2'd0,2'd2,2'd3,3'd7,1'b0,1'b1,4'b0001,3'd0,1'b0,8'd8}   // R8
    };

    task automatic check(input string what, input int tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        link_mode = v.mode; steal_mode = v.steal; link_a = v.a; link_b = v.b;
        own_idx = v.own; bwc_cfg = v.bwc; xfer_done = v.xd; count_zero = v.cz;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset with events pending in an active mode
        rst = 1'b1;
        link_mode = 2'b10; steal_mode = 1'b1; link_a = 2'd1; link_b = 2'd2;
        own_idx = 2'd0; bwc_cfg = 3'd5; xfer_done = 1'b1; count_zero = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("link_req in reset", 1, link_req, 0);
        xfer_done = 1'b0; count_zero = 1'b0;
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("link_req after reset", 1, link_req, 0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            #1;
            check("bwc_eff", 8, bwc_eff, VECS[i].ebwc);
            check("cfg_err", 9, cfg_err, VECS[i].eerr);
            @(posedge clk); @(negedge clk);
            check("link_req pulse", VECS[i].tag, link_req, VECS[i].ereq);
            xfer_done = 1'b0; count_zero = 1'b0;
            @(posedge clk); @(negedge clk);
            check("link_req single cycle", 10, link_req, 0);
        end

        // R10: back-to-back transfers keep the request high two cycles, then drop
        link_mode = 2'b10; steal_mode = 1'b1; link_a = 2'd3; own_idx = 2'd0;
        xfer_done = 1'b1;
        @(posedge clk); @(negedge clk);
        check("back-to-back first", 10, link_req, 4'b1000);
        @(posedge clk); @(negedge clk);
        check("back-to-back second", 10, link_req, 4'b1000);
        xfer_done = 1'b0;
        @(posedge clk); @(negedge clk);
        check("back-to-back end", 10, link_req, 0);

        // R4: transfer then final in mode 01 sequence
        link_mode = 2'b01; link_a = 2'd1; link_b = 2'd3; own_idx = 2'd2;
        xfer_done = 1'b1;
        @(posedge clk); @(negedge clk);
        check("seq per-transfer", 3, link_req, 4'b0010);
        count_zero = 1'b1;
        @(posedge clk); @(negedge clk);
        check("seq final to secondary", 4, link_req, 4'b1000);
        xfer_done = 1'b0; count_zero = 1'b0;
        @(posedge clk); @(negedge clk);
        check("seq idle", 10, link_req, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule